// File: doc/BRIEF.md
# Paired-Kernel Output Lane Multiplexer

This block feeds one output data lane of a sensor readout from two 8-bit converter streams. One stream comes from an even column kernel and the other from an odd one. In image readout it accepts a pair of samples and sends them as two consecutive words, even first. Two other readout modes serve link bring-up. The training mode sends a constant, programmable word on every cycle of a row. The test-image mode sends a byte ramp that restarts with every row. The receiver can use either pattern to align itself before real image data arrives.

One control input powers the pair down together with its lane. While it is asserted the lane goes silent. The readout mode is taken only when a row begins, on the rising edge of the row-active flag, so a row never mixes two modes. All outputs are registered, and each word appears one clock after the inputs that produce it.

Top module: `lane_pair_mux`

## Requirements
- R1: After reset, `lane_vld` is 0, `lane_data` is 0 and the training word register holds the parameter `TRAIN_DEFAULT` (8'h55).
- R2: In image mode (mode code 0), suppose a row is active and both `even_vld` and `odd_vld` are high in cycle t. Then `lane_data` shows the even sample with `lane_vld` high in cycle t+1, and the odd sample in cycle t+2.
- R3: In image mode, a cycle in which only one of `even_vld` and `odd_vld` is high produces no output word.
- R4: If a new pair is presented in the cycle that the pending odd sample is emitted, the odd sample is sent and the new pair is discarded.
- R5: In training mode (mode code 1), every cycle of an active row produces the training register value, and the sample inputs are ignored. A write strobe loads a new training value, which appears from the second cycle after the write.
- R6: In test-image mode (mode code 2), the words of a row are 0, 1, 2 and so on, rising by one per word. The count wraps from 255 to 0, and it restarts at 0 on each row start.
- R7: While `pwr_down` is 1, the next cycle has `lane_vld` 0 and `lane_data` 0. A pending odd sample is discarded, and the test ramp does not advance.
- R8: The mode code is sampled only in the cycle where `row_active` rises. A change of `mode_sel` in the middle of a row has no effect until the next row start.
- R9: While `row_active` is low, no word is produced except a pending odd sample, and `lane_data` is 0 whenever `lane_vld` is 0.
- R10: Mode code 3 behaves as image mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| even_data | input | 8 | Even-kernel sample |
| even_vld | input | 1 | Even-kernel sample valid |
| odd_data | input | 8 | Odd-kernel sample |
| odd_vld | input | 1 | Odd-kernel sample valid |
| pwr_down | input | 1 | 1 powers the pair and its lane down |
| mode_sel | input | 2 | 0 image, 1 training, 2 test ramp, 3 image |
| row_active | input | 1 | High during a row; rising edge is a row start |
| train_wr | input | 1 | Load strobe for the training word |
| train_wdata | input | 8 | New training word |
| lane_data | output | 8 | Output word |
| lane_vld | output | 1 | Output word valid |

## Verification
Two functions can claim the same output cycle. The first is the emission of a buffered odd sample. The second is the acceptance of a fresh even/odd pair, in the cycle right after a pair was taken, or a power-down request in that same cycle. The bench presents a second pair back to back with the first and expects the odd word of the first pair, followed by silence. In a separate test it raises power-down exactly when the odd word is due and expects a zero, invalid word, with no late odd word afterwards.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int SAMPLE_W = 8;

    typedef enum logic [1:0] {
        MODE_IMAGE = 2'd0,
        MODE_TRAIN = 2'd1,
        MODE_TEST  = 2'd2
    } mode_e;

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] data;
    } word_t;

    localparam word_t WORD_IDLE = '{vld: 1'b0, data: '0};

    function automatic mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_TRAIN;
            2'd2:    return MODE_TEST;
            default: return MODE_IMAGE;
        endcase
    endfunction

    function automatic word_t make_word(input logic [SAMPLE_W-1:0] d);
        word_t w;
        w.vld  = 1'b1;
        w.data = d;
        return w;
    endfunction

endpackage

// File: rtl/lpm_row_ctrl.sv
module lpm_row_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       row_active,
    input  logic [1:0] mode_sel,
    output logic       row_start,
    output mode_e      eff_mode,
    output mode_e      act_mode
);
    logic row_q;

    assign row_start = row_active & ~row_q;
    assign eff_mode  = row_start ? decode_mode(mode_sel) : act_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= 1'b0;
            act_mode <= MODE_IMAGE;
        end else begin
            row_q    <= row_active;
            act_mode <= eff_mode;
        end
    end
endmodule

// File: rtl/lpm_pair_buf.sv
module lpm_pair_buf
    import lpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] odd_in,
    output logic                pend,
    output logic [SAMPLE_W-1:0] odd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            odd_q <= '0;
        end else if (flush) begin
            pend  <= 1'b0;
        end else if (pend) begin
            pend  <= 1'b0;
        end else if (take) begin
            pend  <= 1'b1;
            odd_q <= odd_in;
        end
    end
endmodule

// File: rtl/lpm_pattern.sv
module lpm_pattern
    import lpm_pkg::*;
#(
    parameter logic [SAMPLE_W-1:0] TRAIN_DEFAULT = 8'h55
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                advance,
    input  logic                train_wr,
    input  logic [SAMPLE_W-1:0] train_wdata,
    output logic [SAMPLE_W-1:0] ramp_val,
    output logic [SAMPLE_W-1:0] train_q
);
    logic [SAMPLE_W-1:0] cnt_q;

    assign ramp_val = restart ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            train_q <= TRAIN_DEFAULT;
        end else begin
            cnt_q <= advance ? ramp_val + 1'b1 : ramp_val;
            if (train_wr) begin
                train_q <= train_wdata;
            end
        end
    end
endmodule

// File: rtl/lane_pair_mux.sv
module lane_pair_mux
    import lpm_pkg::*;
#(
    parameter logic [SAMPLE_W-1:0] TRAIN_DEFAULT = 8'h55
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] even_data,
    input  logic                even_vld,
    input  logic [SAMPLE_W-1:0] odd_data,
    input  logic                odd_vld,
    input  logic                pwr_down,
    input  logic [1:0]          mode_sel,
    input  logic                row_active,
    input  logic                train_wr,
    input  logic [SAMPLE_W-1:0] train_wdata,
    output logic [SAMPLE_W-1:0] lane_data,
    output logic                lane_vld
);
    logic                row_start;
    mode_e               eff_mode;
    mode_e               act_mode;
    logic                pend;
    logic [SAMPLE_W-1:0] odd_q;
    logic [SAMPLE_W-1:0] ramp_val;
    logic [SAMPLE_W-1:0] train_q;
    logic                pair_in;
    logic                take;
    logic                advance;
    word_t               nxt;
    word_t               out_q;

    lpm_row_ctrl u_row (
        .clk        (clk),
        .rst        (rst),
        .row_active (row_active),
        .mode_sel   (mode_sel),
        .row_start  (row_start),
        .eff_mode   (eff_mode),
        .act_mode   (act_mode)
    );

    assign pair_in = even_vld & odd_vld;
    assign take    = (eff_mode == MODE_IMAGE) & row_active & pair_in & ~pend & ~pwr_down;
    assign advance = (eff_mode == MODE_TEST) & row_active & ~pend & ~pwr_down;

    lpm_pair_buf u_pair (
        .clk    (clk),
        .rst    (rst),
        .flush  (pwr_down),
        .take   (take),
        .odd_in (odd_data),
        .pend   (pend),
        .odd_q  (odd_q)
    );

    lpm_pattern #(
        .TRAIN_DEFAULT (TRAIN_DEFAULT)
    ) u_pat (
        .clk         (clk),
        .rst         (rst),
        .restart     (row_start),
        .advance     (advance),
        .train_wr    (train_wr),
        .train_wdata (train_wdata),
        .ramp_val    (ramp_val),
        .train_q     (train_q)
    );

    always_comb begin
        nxt = WORD_IDLE;
        if (pwr_down) begin
            nxt = WORD_IDLE;
        end else if (pend) begin
            nxt = make_word(odd_q);
        end else if (row_active) begin
            case (eff_mode)
                MODE_TRAIN: nxt = make_word(train_q);
                MODE_TEST:  nxt = make_word(ramp_val);
                default:    nxt = pair_in ? make_word(even_data) : WORD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= WORD_IDLE;
        end else begin
            out_q <= nxt;
        end
    end

    assign lane_data = out_q.data;
    assign lane_vld  = out_q.vld;
endmodule

// File: rtl/lane_pair_mux_chk.sv
module lane_pair_mux_chk
    import lpm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                row_active,
    input logic                pwr_down,
    input logic                lane_vld,
    input logic [SAMPLE_W-1:0] lane_data,
    input logic                pend,
    input logic [SAMPLE_W-1:0] odd_q,
    input mode_e               act_mode,
    input logic [SAMPLE_W-1:0] train_q
);
    // R7
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_down) |-> (!lane_vld && lane_data == '0));

    // R9
    idle_row_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(row_active) && !$past(pend)) |-> !lane_vld);

    // R9
    zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lane_vld |-> lane_data == '0);

    // R2
    odd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(pend) && !$past(pwr_down)) |-> (lane_vld && lane_data == $past(odd_q)));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (row_active && $past(row_active)) |=> $stable(act_mode));

    // R5
    train_word_chk: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_TRAIN && $past(row_active) && !$past(pwr_down) && !$past(pend))
        |-> (lane_vld && lane_data == $past(train_q)));

    // R6
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_TEST && $past(act_mode) == MODE_TEST && $past(row_active)
         && $past(row_active, 2) && lane_vld && $past(lane_vld))
        |-> lane_data == $past(lane_data) + 8'd1);
endmodule

bind lane_pair_mux lane_pair_mux_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .row_active (row_active),
    .pwr_down   (pwr_down),
    .lane_vld   (lane_vld),
    .lane_data  (lane_data),
    .pend       (pend),
    .odd_q      (odd_q),
    .act_mode   (act_mode),
    .train_q    (train_q)
);

// File: tb/lane_pair_mux_tb_top.sv
module lane_pair_mux_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] even_data = '0;
    logic       even_vld = 1'b0;
    logic [7:0] odd_data = '0;
    logic       odd_vld = 1'b0;
    logic       pwr_down = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       row_active = 1'b0;
    logic       train_wr = 1'b0;
    logic [7:0] train_wdata = '0;
    logic [7:0] lane_data;
    logic       lane_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lane_pair_mux dut_i (
        .clk(clk), .rst(rst),
        .even_data(even_data), .even_vld(even_vld),
        .odd_data(odd_data), .odd_vld(odd_vld),
        .pwr_down(pwr_down), .mode_sel(mode_sel), .row_active(row_active),
        .train_wr(train_wr), .train_wdata(train_wdata),
        .lane_data(lane_data), .lane_vld(lane_vld)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_word(string req, logic v, logic [7:0] d);
        checks++;
        if (lane_vld !== v || lane_data !== d) begin
            failures++;
            $display("FAIL %s: got vld=%0b data=%02h, expected vld=%0b data=%02h",
                     req, lane_vld, lane_data, v, d);
        end
    endtask

    task automatic set_pair(logic ev, logic [7:0] e, logic ov, logic [7:0] o);
        even_vld = ev; even_data = e; odd_vld = ov; odd_data = o;
    endtask

    task automatic new_row(logic [1:0] m);
        row_active = 1'b0;
        set_pair(0, 0, 0, 0);
        tick();
        tick();
        mode_sel = m;
        row_active = 1'b1;
    endtask

    task automatic t_reset();
        expect_word("R1 reset idle", 0, 8'h00);
    endtask

    task automatic t_image();
        new_row(2'd0);
        set_pair(1, 8'h11, 1, 8'h22);
        tick();
        expect_word("R2 even first", 1, 8'h11);
        set_pair(0, 0, 0, 0);
        tick();
        expect_word("R2 odd second", 1, 8'h22);
        tick();
        expect_word("R2 idle after pair", 0, 8'h00);
    endtask

    task automatic t_single();
        set_pair(1, 8'h33, 0, 8'h44);
        tick();
        expect_word("R3 even only", 0, 8'h00);
        set_pair(0, 8'h33, 1, 8'h44);
        tick();
        expect_word("R3 odd only", 0, 8'h00);
        set_pair(0, 0, 0, 0);
    endtask

    task automatic t_collide();
        set_pair(1, 8'hA1, 1, 8'hB1);
        tick();
        expect_word("R4 first even", 1, 8'hA1);
        set_pair(1, 8'hA2, 1, 8'hB2);
        tick();
        expect_word("R4 odd wins", 1, 8'hB1);
        set_pair(0, 0, 0, 0);
        tick();
        expect_word("R4 second pair dropped", 0, 8'h00);
    endtask

    task automatic t_outside_row();
        row_active = 1'b0;
        set_pair(0, 0, 0, 0);
        tick();
        set_pair(1, 8'h5A, 1, 8'hA5);
        tick();
        expect_word("R9 no output outside row", 0, 8'h00);
        set_pair(0, 0, 0, 0);
    endtask

    task automatic t_mode3();
        new_row(2'd3);
        set_pair(1, 8'h71, 1, 8'h72);
        tick();
        expect_word("R10 code3 even", 1, 8'h71);
        set_pair(0, 0, 0, 0);
        tick();
        expect_word("R10 code3 odd", 1, 8'h72);
    endtask

    task automatic t_train();
        new_row(2'd1);
        set_pair(1, 8'h99, 1, 8'h98);
        tick();
        expect_word("R1 default training word", 1, 8'h55);
        train_wr = 1'b1; train_wdata = 8'h3C;
        tick();
        train_wr = 1'b0;
        expect_word("R5 old word during write", 1, 8'h55);
        tick();
        expect_word("R5 new training word", 1, 8'h3C);
        set_pair(0, 0, 0, 0);
    endtask

    task automatic t_ramp();
        int bad = 0;
        new_row(2'd2);
        for (int i = 0; i < 300; i++) begin
            tick();
            if (lane_vld !== 1'b1 || lane_data !== 8'(i)) bad++;
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL R6 ramp with wrap: got %0d bad words, expected 0", bad);
        end
        mode_sel = 2'd1;
        tick();
        expect_word("R8 mid-row mode change ignored", 1, 8'(300));
        new_row(2'd2);
        tick();
        expect_word("R6 restart at row start", 1, 8'h00);
        tick();
        expect_word("R6 second word", 1, 8'h01);
        mode_sel = 2'd0;
        new_row(2'd1);
        tick();
        expect_word("R8 new mode at next row", 1, 8'h3C);
    endtask

    task automatic t_power();
        new_row(2'd0);
        set_pair(1, 8'hC1, 1, 8'hD1);
        tick();
        expect_word("R7 even before power down", 1, 8'hC1);
        set_pair(0, 0, 0, 0);
        pwr_down = 1'b1;
        tick();
        expect_word("R7 odd suppressed", 0, 8'h00);
        pwr_down = 1'b0;
        tick();
        expect_word("R7 odd discarded", 0, 8'h00);
        new_row(2'd2);
        tick();
        tick();
        expect_word("R7 ramp before power down", 1, 8'h01);
        pwr_down = 1'b1;
        tick();
        expect_word("R7 powered down silent", 0, 8'h00);
        tick();
        pwr_down = 1'b0;
        tick();
        expect_word("R7 ramp resumes without advancing", 1, 8'h02);
        row_active = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        tick();
        t_reset();
        t_image();
        t_single();
        t_collide();
        t_outside_row();
        t_mode3();
        t_train();
        t_ramp();
        t_power();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule